// File: doc/BRIEF.md
# User Mode Control Register with Floating-Point Write Tracking

This block holds the per-thread user-mode control bits that the rest of the core reads every cycle. Three of them are modes that software sets: big-endian data ordering, enabling user performance monitors, and strict alignment checking. Two more are status flags that hardware sets. They record whether any completed instruction has written a floating-point register in the low bank (registers 2 to 31) or in the high bank (registers 32 to 127). Context-switch code can use these flags to skip saving a bank that was never touched.

Software updates the register with an explicit write of the whole mask. The retire stage reports each completing instruction that has a floating-point destination, together with that register number. The status flags are sticky: once set, only a software write can clear them. Registers 0 and 1 are constant registers and never set a flag. The register contents are always visible on `mask_o`, and each mode bit is also driven on its own output.

Top module: `umask_reg`

## Requirements
- R1: On reset (`rst_ni` low, asynchronous) the whole mask reads 0.
- R2: A write (`wr_en_i` high) loads mask bits 5..1 from `wr_data_i` on the next clock edge. Bit 0 is reserved and always reads 0.
- R3: A completion (`cmpl_valid_i` high) whose `cmpl_fp_dst_i` is in the range 2..31 sets mask bit 4 on the next edge.
- R4: A completion whose `cmpl_fp_dst_i` is in the range 32..127 sets mask bit 5 on the next edge.
- R5: A completion that targets register 0 or 1 sets neither bit 4 nor bit 5.
- R6: Bits 4 and 5 hold their value on every cycle without a write, including cycles where `cmpl_valid_i` is low with any register number applied.
- R7: Only a write clears bit 4 or bit 5. Writing a 0 to them clears them.
- R8: When a write and a completion fall in the same cycle, the written value is applied first and the completion's flag is then ORed into it.
- R9: `big_endian_o`, `pm_enable_o` and `align_strict_o` always equal mask bits 1, 2 and 3 respectively.
- R10: A completion never changes mask bits 3..1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Explicit software write of the mask |
| wr_data_i | input | 6 | Mask value to write |
| cmpl_valid_i | input | 1 | An instruction with a floating-point destination completes |
| cmpl_fp_dst_i | input | 7 | Floating-point destination register number |
| mask_o | output | 6 | Current mask contents |
| big_endian_o | output | 1 | Mask bit 1: big-endian data ordering |
| pm_enable_o | output | 1 | Mask bit 2: user performance monitors enabled |
| align_strict_o | output | 1 | Mask bit 3: every unaligned data access faults |

## Verification
A software write and a retiring floating-point completion can land in the same cycle. That is the one place where the order of clear and set shows up. The bench drives both together with a write value whose flag bits are zero and a destination in each bank. It expects the written mode bits together with exactly the flag for that destination's bank, which shows the write went first and the set was ORed over it. The bench also checks the neighbouring cycles, to confirm that flags set earlier do not survive the write.

// File: rtl/umask_pkg.sv
package umask_pkg;
  localparam int UM_W   = 6;
  localparam int BE_BIT = 1;
  localparam int PM_BIT = 2;
  localparam int AC_BIT = 3;
  localparam int FL_BIT = 4;
  localparam int FH_BIT = 5;
  // bit 0 reserved, never stored
  localparam logic [UM_W-1:0] WR_MASK = 6'b111110;
endpackage

// File: rtl/umask_fp_classify.sv
module umask_fp_classify #(
  parameter int FP_IDX_W = 7,
  parameter int LO_BASE  = 2,
  parameter int HI_BASE  = 32
) (
  input  logic                cmpl_valid_i,
  input  logic [FP_IDX_W-1:0] cmpl_fp_dst_i,
  output logic                hit_lo_o,
  output logic                hit_hi_o
);
  localparam logic [FP_IDX_W-1:0] LO_B = FP_IDX_W'(LO_BASE);
  localparam logic [FP_IDX_W-1:0] HI_B = FP_IDX_W'(HI_BASE);

  always_comb begin
    hit_lo_o = cmpl_valid_i && (cmpl_fp_dst_i >= LO_B) && (cmpl_fp_dst_i < HI_B);
    hit_hi_o = cmpl_valid_i && (cmpl_fp_dst_i >= HI_B);
  end
endmodule

// File: rtl/umask_store.sv
module umask_store
  import umask_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [UM_W-1:0] wr_data_i,
  input  logic            set_lo_i,
  input  logic            set_hi_i,
  output logic [UM_W-1:0] mask_q_o
);
  logic [UM_W-1:0] mask_q, base_d, set_v, mask_d;

  always_comb begin
    set_v         = '0;
    set_v[FL_BIT] = set_lo_i;
    set_v[FH_BIT] = set_hi_i;
    base_d        = wr_en_i ? (wr_data_i & WR_MASK) : mask_q;
    // write first, then hardware set ORed in
    mask_d        = base_d | set_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_q_o = mask_q;

  // R7
  fl_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && mask_q[FL_BIT]) |=> mask_q[FL_BIT]);
  // R7
  fh_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && mask_q[FH_BIT]) |=> mask_q[FH_BIT]);
  // R2
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !set_lo_i && !set_hi_i) |=> mask_q == ($past(wr_data_i) & WR_MASK));
  // R10
  mode_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q[AC_BIT:BE_BIT]));
endmodule

// File: rtl/umask_reg.sv
module umask_reg
  import umask_pkg::*;
#(
  parameter int FP_IDX_W = 7,
  parameter int LO_BASE  = 2,
  parameter int HI_BASE  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [UM_W-1:0]     wr_data_i,
  input  logic                cmpl_valid_i,
  input  logic [FP_IDX_W-1:0] cmpl_fp_dst_i,
  output logic [UM_W-1:0]     mask_o,
  output logic                big_endian_o,
  output logic                pm_enable_o,
  output logic                align_strict_o
);
  localparam logic [FP_IDX_W-1:0] LO_B = FP_IDX_W'(LO_BASE);
  localparam logic [FP_IDX_W-1:0] HI_B = FP_IDX_W'(HI_BASE);

  logic hit_lo, hit_hi;

  umask_fp_classify #(
    .FP_IDX_W(FP_IDX_W),
    .LO_BASE (LO_BASE),
    .HI_BASE (HI_BASE)
  ) i_classify (
    .cmpl_valid_i (cmpl_valid_i),
    .cmpl_fp_dst_i(cmpl_fp_dst_i),
    .hit_lo_o     (hit_lo),
    .hit_hi_o     (hit_hi)
  );

  umask_store i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .set_lo_i (hit_lo),
    .set_hi_i (hit_hi),
    .mask_q_o (mask_o)
  );

  assign big_endian_o   = mask_o[BE_BIT];
  assign pm_enable_o    = mask_o[PM_BIT];
  assign align_strict_o = mask_o[AC_BIT];

  // R3
  lo_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_valid_i && cmpl_fp_dst_i >= LO_B && cmpl_fp_dst_i < HI_B) |=> mask_o[FL_BIT]);
  // R4
  hi_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_valid_i && cmpl_fp_dst_i >= HI_B) |=> mask_o[FH_BIT]);
  // R5
  const_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && cmpl_valid_i && cmpl_fp_dst_i < LO_B)
      |=> mask_o[FH_BIT:FL_BIT] == $past(mask_o[FH_BIT:FL_BIT]));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !cmpl_valid_i) |=> $stable(mask_o));
endmodule

// File: tb/test_umask_reg.sv
module test_umask_reg;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       wr;
    logic [5:0] data;
    logic       cv;
    logic [6:0] dst;
    logic [5:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 6'h00, 1'b1, 7'd0,   6'h00},  // R5 reg 0
    '{1'b0, 6'h00, 1'b1, 7'd1,   6'h00},  // R5 reg 1
    '{1'b0, 6'h00, 1'b1, 7'd2,   6'h10},  // R3 low edge
    '{1'b1, 6'h00, 1'b0, 7'd0,   6'h00},  // R7 clear by write
    '{1'b0, 6'h00, 1'b1, 7'd31,  6'h10},  // R3 high edge
    '{1'b0, 6'h00, 1'b1, 7'd32,  6'h30},  // R4 low edge
    '{1'b0, 6'h00, 1'b0, 7'd0,   6'h30},  // R6 hold
    '{1'b1, 6'h0E, 1'b0, 7'd0,   6'h0E},  // R2 write modes, R7 clears flags
    '{1'b0, 6'h00, 1'b1, 7'd127, 6'h2E},  // R4 top, R10 modes kept
    '{1'b1, 6'h3F, 1'b0, 7'd0,   6'h3E},  // R2 bit 0 reserved
    '{1'b1, 6'h02, 1'b1, 7'd5,   6'h12},  // R8 write then set low
    '{1'b1, 6'h00, 1'b1, 7'd64,  6'h20},  // R8 write then set high
    '{1'b0, 6'h00, 1'b0, 7'd10,  6'h20},  // R6 invalid completion ignored
    '{1'b1, 6'h0C, 1'b0, 7'd0,   6'h0C}   // R2 / R9 decode below
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [5:0] wr_data_i = '0;
  logic       cmpl_valid_i = 1'b0;
  logic [6:0] cmpl_fp_dst_i = '0;
  logic [5:0] mask_o;
  logic       big_endian_o, pm_enable_o, align_strict_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  umask_reg i_umask_reg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .cmpl_valid_i  (cmpl_valid_i),
    .cmpl_fp_dst_i (cmpl_fp_dst_i),
    .mask_o        (mask_o),
    .big_endian_o  (big_endian_o),
    .pm_enable_o   (pm_enable_o),
    .align_strict_o(align_strict_o)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [5:0] d, input logic cv, input logic [6:0] dst);
    wr_en_i = wr; wr_data_i = d; cmpl_valid_i = cv; cmpl_fp_dst_i = dst;
    @(negedge clk_i);
    wr_en_i = 1'b0; cmpl_valid_i = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset value
    chk("R1", mask_o, 6'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", mask_o, 6'h00);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].wr, TBL[i].data, TBL[i].cv, TBL[i].dst);
      chk($sformatf("table step %0d", i), mask_o, TBL[i].exp);
    end

    // R9 decoded mode outputs after 0x0C
    chk("R9", {3'b0, align_strict_o, pm_enable_o, big_endian_o}, 6'b000110);
    step(1'b1, 6'h02, 1'b0, 7'd0);
    chk("R9", {3'b0, align_strict_o, pm_enable_o, big_endian_o}, 6'b000001);

    // R10 completions in both banks keep mode bits
    step(1'b0, 6'h00, 1'b1, 7'd20);
    step(1'b0, 6'h00, 1'b1, 7'd100);
    chk("R10", mask_o, 6'h32);

    // R6 invalid completion with high-bank number after clear
    step(1'b1, 6'h00, 1'b0, 7'd0);
    step(1'b0, 6'h00, 1'b0, 7'd99);
    chk("R6", mask_o, 6'h00);

    // R1 asynchronous reset mid-run
    step(1'b1, 6'h3E, 1'b0, 7'd0);
    chk("R2", mask_o, 6'h3E);
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #1 chk("R1", mask_o, 6'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", mask_o, 6'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (1000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule